// File: doc/BRIEF.md
# Fractional-N spread-spectrum modulator

This block supplies, once per reference clock cycle, the feedback division ratio that a fractional-N PLL's divider or delta-sigma stage consumes. The ratio is a fixed-point number: an 8-bit whole part above an 18-bit fractional part. The fraction is presented as three fields: low byte, middle byte and top two bits. When spreading is turned off the block passes that nominal ratio straight through. When it is on, the block subtracts a triangular offset from the ratio. The offset climbs for one half-period and falls for the next. It moves by a programmed step once every (adjust period + 1) reference cycles.

Two spread shapes are offered. Down-spread only ever lowers the ratio. Centre-spread lifts the whole triangle by half its peak, so the ratio swings symmetrically about the nominal value. All programming inputs are sampled into shadow registers only when a modulation period begins, so software may rewrite them at any time without tearing a sweep.

Top module: `frac_ssc_mod`

## Requirements
- R1: In every cycle that follows a cycle with the enable (control bit 1) low, `ratio_o` equals the live nominal ratio `{int_i, frac_hi_i, frac_mid_i, frac_lo_i}` of that same cycle, with no offset.
- R2: At the first clock edge at which the enable is seen high while the block is idle, the nominal ratio, half-period, step, adjust period and centre select (control bit 0) are captured. The sweep starts in the next cycle at position 0 with zero offset.
- R3: Inside a half-period, the offset moves by exactly one step at the edge after each cycle in which the adjust counter reaches the adjust period. Steps are therefore (adjust period + 1) cycles apart, and an adjust period of 0 steps every cycle.
- R4: A half-period lasts (half-period value + 1) cycles. The offset rises during the first half of each modulation period and falls during the second.
- R5: The adjust counter restarts at every half-period boundary. Each half therefore holds N = floor((half-period + 1) / (adjust + 1)) steps, the peak offset is N × step, and the offset is back at exactly zero when each period ends, with no drift over any number of periods.
- R6: With control bit 0 clear (down-spread), `ratio_o` = nominal − offset, taken modulo 2^26 (ratio LSB = one fraction LSB).
- R7: With control bit 0 set (centre-spread), `ratio_o` = nominal − offset + floor(N × step / 2), modulo 2^26.
- R8: Changes to any programming input (nominal, half-period, step, adjust period, centre select) while a sweep runs have no effect until the edge that ends the current modulation period, where they are captured afresh.
- R9: Clearing the enable stops the sweep at the next edge. Setting it again starts a fresh period from position 0, as in R2.
- R10: After reset the block is idle and `ratio_o` follows the live nominal ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one ratio per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_i | input | 8 | Whole part of the nominal ratio |
| frac_lo_i | input | 8 | Fraction bits 7..0 |
| frac_mid_i | input | 8 | Fraction bits 15..8 |
| frac_hi_i | input | 2 | Fraction bits 17..16 |
| half_per_i | input | 16 | Half-period length minus one, in reference cycles |
| step_i | input | 16 | Offset increment per step, in fraction LSBs |
| adj_per_i | input | 16 | Cycles between steps minus one |
| ctrl_i | input | 2 | Bit 1 enable spreading, bit 0 centre-spread select |
| ratio_o | output | 26 | Instantaneous division ratio, whole part in bits 25..18 |

## Verification
The delicate coincidence is the last step of a half-period landing on the same cycle as the direction flip. At the end of a period this also meets the shadow reload. The bench provokes it by choosing a half-period length that is an exact multiple of (adjust + 1), and by rewriting every programming input partway through a period. A behavioural model derives the expected offset in closed form from the position within the period, not from counters. It is compared with `ratio_o` every cycle, so a lost, doubled or misplaced step at the boundary, or an early reload, shows up as a mismatch in the following period.

// File: rtl/frac_ssc_pkg.sv
package frac_ssc_pkg;

  localparam int SSC_INT_W  = 8;
  localparam int SSC_FRAC_W = 18;
  localparam int SSC_CNT_W  = 16;
  localparam int SSC_OFS_W  = 32;

  typedef enum logic {
    RAMP_UP   = 1'b0,
    RAMP_DOWN = 1'b1
  } ramp_dir_e;

endpackage

// File: rtl/ssc_rst_sync.sv
module ssc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ssc_sweep_timer.sv
module ssc_sweep_timer
  import frac_ssc_pkg::*;
#(
  parameter int CNT_W = SSC_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [CNT_W-1:0] half_max,
  input  logic [CNT_W-1:0] adj_max,
  output logic             step_now,
  output logic             half_end,
  output ramp_dir_e        dir_o,
  output logic [CNT_W-1:0] half_cnt_o,
  output logic [CNT_W-1:0] adj_cnt_o
);

  logic [CNT_W-1:0] half_q, half_d;
  logic [CNT_W-1:0] adj_q, adj_d;
  ramp_dir_e        dir_q, dir_d;

  assign half_end = (half_q == half_max);
  assign step_now = (adj_q == adj_max);

  always_comb begin
    half_d = half_q;
    adj_d  = adj_q;
    dir_d  = dir_q;
    if (clear) begin
      half_d = '0;
      adj_d  = '0;
      dir_d  = RAMP_UP;
    end else if (advance) begin
      half_d = half_end ? '0 : half_q + CNT_W'(1);
      adj_d  = (step_now || half_end) ? '0 : adj_q + CNT_W'(1);
      if (half_end) begin
        dir_d = (dir_q == RAMP_UP) ? RAMP_DOWN : RAMP_UP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      adj_q  <= '0;
      dir_q  <= RAMP_UP;
    end else begin
      half_q <= half_d;
      adj_q  <= adj_d;
      dir_q  <= dir_d;
    end
  end

  assign dir_o      = dir_q;
  assign half_cnt_o = half_q;
  assign adj_cnt_o  = adj_q;

endmodule

// File: rtl/ssc_ramp_acc.sv
module ssc_ramp_acc
  import frac_ssc_pkg::*;
#(
  parameter int CNT_W = SSC_CNT_W,
  parameter int OFS_W = SSC_OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step_en,
  input  ramp_dir_e        dir,
  input  logic [CNT_W-1:0] step,
  output logic [OFS_W-1:0] offset_o
);

  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic [OFS_W-1:0] step_ext;

  assign step_ext = OFS_W'(step);

  always_comb begin
    ofs_d = ofs_q;
    if (clear) begin
      ofs_d = '0;
    end else if (step_en) begin
      if (dir == RAMP_UP) begin
        ofs_d = ofs_q + step_ext;
      end else begin
        ofs_d = ofs_q - step_ext;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else begin
      ofs_q <= ofs_d;
    end
  end

  assign offset_o = ofs_q;

endmodule

// File: rtl/ssc_ratio_mix.sv
module ssc_ratio_mix
  import frac_ssc_pkg::*;
#(
  parameter int RATIO_W = SSC_INT_W + SSC_FRAC_W,
  parameter int CNT_W   = SSC_CNT_W,
  parameter int OFS_W   = SSC_OFS_W
) (
  input  logic               active,
  input  logic               centre,
  input  logic [RATIO_W-1:0] nom_sh,
  input  logic [RATIO_W-1:0] live_nom,
  input  logic [OFS_W-1:0]   offset,
  input  logic [CNT_W-1:0]   half_max,
  input  logic [CNT_W-1:0]   adj_max,
  input  logic [CNT_W-1:0]   step,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [OFS_W-1:0]   peak_o
);

  localparam int DIV_W = CNT_W + 1;

  logic [DIV_W-1:0]   half_len;
  logic [DIV_W-1:0]   adj_len;
  logic [DIV_W-1:0]   n_steps;
  logic [OFS_W-1:0]   peak;
  logic [OFS_W-1:0]   bias;
  logic [RATIO_W-1:0] swept;

  always_comb begin
    half_len = {1'b0, half_max} + DIV_W'(1);
    adj_len  = {1'b0, adj_max} + DIV_W'(1);
    n_steps  = half_len / adj_len;
    peak     = OFS_W'(n_steps) * OFS_W'(step);
    bias     = centre ? (peak >> 1) : '0;
    swept    = nom_sh - RATIO_W'(offset) + RATIO_W'(bias);
    ratio_o  = active ? swept : live_nom;
  end

  assign peak_o = peak;

endmodule

// File: rtl/frac_ssc_mod.sv
module frac_ssc_mod
  import frac_ssc_pkg::*;
#(
  parameter int INT_W  = SSC_INT_W,
  parameter int FRAC_W = SSC_FRAC_W,
  parameter int CNT_W  = SSC_CNT_W,
  parameter int OFS_W  = SSC_OFS_W,
  parameter int SYNC_N = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [INT_W-1:0]          int_i,
  input  logic [7:0]                frac_lo_i,
  input  logic [7:0]                frac_mid_i,
  input  logic [FRAC_W-17:0]        frac_hi_i,
  input  logic [CNT_W-1:0]          half_per_i,
  input  logic [CNT_W-1:0]          step_i,
  input  logic [CNT_W-1:0]          adj_per_i,
  input  logic [1:0]                ctrl_i,
  output logic [INT_W+FRAC_W-1:0]   ratio_o
);

  localparam int RATIO_W = INT_W + FRAC_W;

  logic               rst_sync_n;
  logic [RATIO_W-1:0] live_nom;
  logic               en;
  logic               centre_sel;

  logic               active_q;
  logic               active_d;
  logic [RATIO_W-1:0] nom_sh, nom_sh_d;
  logic [CNT_W-1:0]   half_sh, half_sh_d;
  logic [CNT_W-1:0]   step_sh, step_sh_d;
  logic [CNT_W-1:0]   adj_sh, adj_sh_d;
  logic               centre_sh, centre_sh_d;

  logic               step_now;
  logic               half_end;
  ramp_dir_e          dir_q;
  logic [CNT_W-1:0]   half_cnt;
  logic [CNT_W-1:0]   adj_cnt;
  logic [OFS_W-1:0]   offset;
  logic [OFS_W-1:0]   peak;

  logic               period_end;
  logic               load;
  logic               clear;
  logic               advance;
  logic               step_en;

  assign live_nom   = {int_i, frac_hi_i, frac_mid_i, frac_lo_i};
  assign en         = ctrl_i[1];
  assign centre_sel = ctrl_i[0];

  ssc_rst_sync #(
    .STAGES (SYNC_N)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // sequencing of the sweep
  always_comb begin
    period_end = active_q && half_end && (dir_q == RAMP_DOWN);
    load       = en && (!active_q || period_end);
    clear      = !en || load;
    advance    = en && active_q && !load;
    step_en    = advance && step_now;
    active_d   = en;
  end

  // shadow next-state
  always_comb begin
    nom_sh_d    = nom_sh;
    half_sh_d   = half_sh;
    step_sh_d   = step_sh;
    adj_sh_d    = adj_sh;
    centre_sh_d = centre_sh;
    if (load) begin
      nom_sh_d    = live_nom;
      half_sh_d   = half_per_i;
      step_sh_d   = step_i;
      adj_sh_d    = adj_per_i;
      centre_sh_d = centre_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      active_q  <= 1'b0;
      nom_sh    <= '0;
      half_sh   <= '0;
      step_sh   <= '0;
      adj_sh    <= '0;
      centre_sh <= 1'b0;
    end else begin
      active_q  <= active_d;
      nom_sh    <= nom_sh_d;
      half_sh   <= half_sh_d;
      step_sh   <= step_sh_d;
      adj_sh    <= adj_sh_d;
      centre_sh <= centre_sh_d;
    end
  end

  ssc_sweep_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clear      (clear),
    .advance    (advance),
    .half_max   (half_sh),
    .adj_max    (adj_sh),
    .step_now   (step_now),
    .half_end   (half_end),
    .dir_o      (dir_q),
    .half_cnt_o (half_cnt),
    .adj_cnt_o  (adj_cnt)
  );

  ssc_ramp_acc #(
    .CNT_W (CNT_W),
    .OFS_W (OFS_W)
  ) u_ramp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear    (clear),
    .step_en  (step_en),
    .dir      (dir_q),
    .step     (step_sh),
    .offset_o (offset)
  );

  ssc_ratio_mix #(
    .RATIO_W (RATIO_W),
    .CNT_W   (CNT_W),
    .OFS_W   (OFS_W)
  ) u_mix (
    .active   (active_q),
    .centre   (centre_sh),
    .nom_sh   (nom_sh),
    .live_nom (live_nom),
    .offset   (offset),
    .half_max (half_sh),
    .adj_max  (adj_sh),
    .step     (step_sh),
    .ratio_o  (ratio_o),
    .peak_o   (peak)
  );

endmodule

// File: rtl/frac_ssc_mod_chk.sv
module frac_ssc_mod_chk
  import frac_ssc_pkg::*;
#(
  parameter int RATIO_W = SSC_INT_W + SSC_FRAC_W,
  parameter int CNT_W   = SSC_CNT_W,
  parameter int OFS_W   = SSC_OFS_W
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [1:0]         ctrl_i,
  input logic [RATIO_W-1:0] live_nom,
  input logic [RATIO_W-1:0] ratio_o,
  input logic               active_q,
  input logic               period_end,
  input logic [OFS_W-1:0]   offset,
  input logic [OFS_W-1:0]   peak,
  input logic [CNT_W-1:0]   half_cnt,
  input logic [CNT_W-1:0]   adj_cnt,
  input logic [CNT_W-1:0]   half_sh,
  input logic [CNT_W-1:0]   step_sh,
  input logic [CNT_W-1:0]   adj_sh,
  input logic               half_end,
  input logic               step_now,
  input ramp_dir_e          dir_q
);

  AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_i[1] |=> (ratio_o == live_nom)); // R1

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(active_q) |-> (offset == '0) && (half_cnt == '0) && (dir_q == RAMP_UP)); // R2

  AST_ADJ_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    active_q |-> (adj_cnt <= adj_sh)); // R3

  AST_HALF_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    active_q |-> (half_cnt <= half_sh)); // R4

  AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    active_q |-> (offset <= peak)); // R5

  AST_RAMP_RETURNS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (active_q && half_end && dir_q == RAMP_DOWN) |->
      (offset == (step_now ? OFS_W'(step_sh) : '0))); // R5

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (active_q && ctrl_i[1] && !period_end) |=>
      ($stable(step_sh) && $stable(half_sh) && $stable(adj_sh))); // R8

endmodule

bind frac_ssc_mod frac_ssc_mod_chk #(
  .RATIO_W (RATIO_W),
  .CNT_W   (CNT_W),
  .OFS_W   (OFS_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .ctrl_i     (ctrl_i),
  .live_nom   (live_nom),
  .ratio_o    (ratio_o),
  .active_q   (active_q),
  .period_end (period_end),
  .offset     (offset),
  .peak       (peak),
  .half_cnt   (half_cnt),
  .adj_cnt    (adj_cnt),
  .half_sh    (half_sh),
  .step_sh    (step_sh),
  .adj_sh     (adj_sh),
  .half_end   (half_end),
  .step_now   (step_now),
  .dir_q      (dir_q)
);

// File: tb/frac_ssc_mod_test.sv
module frac_ssc_mod_test;

  localparam int CLK_NS  = 10;
  localparam int RATIO_W = 26;

  logic        clk;
  logic        rst_n;
  logic [7:0]  int_i;
  logic [7:0]  frac_lo_i;
  logic [7:0]  frac_mid_i;
  logic [1:0]  frac_hi_i;
  logic [15:0] half_per_i;
  logic [15:0] step_i;
  logic [15:0] adj_per_i;
  logic [1:0]  ctrl_i;
  logic [25:0] ratio_o;

  int    compared;
  int    mismatched;
  bit    done;
  string cur_tag;

  // reference model state
  bit     m_active;
  longint m_t;
  longint m_nom, m_per, m_step, m_adj;
  bit     m_ctr;

  frac_ssc_mod uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_i      (int_i),
    .frac_lo_i  (frac_lo_i),
    .frac_mid_i (frac_mid_i),
    .frac_hi_i  (frac_hi_i),
    .half_per_i (half_per_i),
    .step_i     (step_i),
    .adj_per_i  (adj_per_i),
    .ctrl_i     (ctrl_i),
    .ratio_o    (ratio_o)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  function automatic longint live_nominal();
    return (longint'(int_i) << 18) | (longint'(frac_hi_i) << 16) |
           (longint'(frac_mid_i) << 8) | longint'(frac_lo_i);
  endfunction

  function automatic longint expected_ratio();
    longint half, n, pos, ofs, r;
    if (!m_active) return live_nominal();
    half = m_per + 1;
    n    = half / (m_adj + 1);
    if (m_t < half) begin
      pos = m_t;
      ofs = m_step * (pos / (m_adj + 1));
    end else begin
      pos = m_t - half;
      ofs = m_step * (n - pos / (m_adj + 1));
    end
    r = m_nom - ofs + (m_ctr ? (n * m_step) / 2 : 0);
    return r & ((longint'(1) << RATIO_W) - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active <= 1'b0;
      m_t      <= 0;
    end else if (!ctrl_i[1]) begin
      m_active <= 1'b0;
      m_t      <= 0;
    end else if (!m_active || m_t == 2 * (m_per + 1) - 1) begin
      m_active <= 1'b1;
      m_t      <= 0;
      m_nom    <= live_nominal();
      m_per    <= longint'(half_per_i);
      m_step   <= longint'(step_i);
      m_adj    <= longint'(adj_per_i);
      m_ctr    <= ctrl_i[0];
    end else begin
      m_t <= m_t + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      longint exp_v;
      exp_v = expected_ratio();
      compared++;
      if (longint'(ratio_o) != exp_v) begin
        mismatched++;
        $display("FAIL %s t=%0t ratio actual=0x%07h expected=0x%07h",
                 cur_tag, $time, ratio_o, exp_v[25:0]);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic program_cfg(input int nom_int, input int frac, input int per,
                             input int stp, input int adj, input bit en,
                             input bit ctr);
    int_i      = 8'(nom_int);
    frac_lo_i  = 8'(frac);
    frac_mid_i = 8'(frac >> 8);
    frac_hi_i  = 2'(frac >> 16);
    half_per_i = 16'(per);
    step_i     = 16'(stp);
    adj_per_i  = 16'(adj);
    ctrl_i     = {en, ctr};
  endtask

  initial begin
    compared   = 0;
    mismatched = 0;
    done       = 1'b0;
    cur_tag    = "R10";
    rst_n      = 1'b0;
    program_cfg(8'h40, 18'h12345, 5, 10, 1, 1'b0, 1'b0);

    // R10: reset state follows the live nominal
    tick(3);
    rst_n = 1'b1;
    tick(5);

    // R1: disabled, nominal changes pass through, other inputs ignored
    cur_tag = "R1";
    for (int i = 0; i < 6; i++) begin
      program_cfg(8'h10 + i, 18'h3A5C0 + i * 77, 3 + i, 50 * i, i, 1'b0, i[0]);
      tick(1);
    end

    // R2: start of a down sweep
    cur_tag = "R2";
    program_cfg(8'h40, 18'h12345, 5, 10, 1, 1'b1, 1'b0);
    tick(3);

    // R3 / R6: steps every second cycle, several periods of down-spread
    cur_tag = "R3";
    tick(20);
    cur_tag = "R6";
    tick(16);

    // R4: adjust period 0, a step every cycle
    cur_tag = "R4";
    program_cfg(8'h22, 18'h00FF0, 3, 7, 0, 1'b0, 1'b0);
    tick(1);
    program_cfg(8'h22, 18'h00FF0, 3, 7, 0, 1'b1, 1'b0);
    tick(24);

    // R5: half length 7 not a multiple of 3, and half 8 a multiple of 2
    cur_tag = "R5";
    program_cfg(8'h30, 18'h20001, 6, 13, 2, 1'b0, 1'b0);
    tick(1);
    program_cfg(8'h30, 18'h20001, 6, 13, 2, 1'b1, 1'b0);
    tick(45);
    program_cfg(8'h31, 18'h00000, 7, 9, 1, 1'b1, 1'b0);
    tick(50);
    // adjust longer than the half: no steps at all
    program_cfg(8'h31, 18'h00000, 2, 99, 9, 1'b0, 1'b0);
    tick(1);
    program_cfg(8'h31, 18'h00000, 2, 99, 9, 1'b1, 1'b0);
    tick(14);

    // R6: underflow wraps modulo 2^26
    cur_tag = "R6";
    program_cfg(8'h00, 18'h00005, 4, 100, 0, 1'b0, 1'b0);
    tick(1);
    program_cfg(8'h00, 18'h00005, 4, 100, 0, 1'b1, 1'b0);
    tick(22);

    // R7: centre-spread with odd peak (N=3, step 5, bias 7)
    cur_tag = "R7";
    program_cfg(8'h50, 18'h10000, 5, 5, 1, 1'b0, 1'b1);
    tick(1);
    program_cfg(8'h50, 18'h10000, 5, 5, 1, 1'b1, 1'b1);
    tick(30);

    // R8: reprogram mid-period, new values only from the next period
    cur_tag = "R8";
    program_cfg(8'h60, 18'h0ABCD, 5, 10, 1, 1'b0, 1'b0);
    tick(1);
    program_cfg(8'h60, 18'h0ABCD, 5, 10, 1, 1'b1, 1'b0);
    tick(4);
    program_cfg(8'h61, 18'h3FFFF, 2, 3, 0, 1'b1, 1'b1);
    tick(30);

    // R9: disable mid-period, then restart from position 0
    cur_tag = "R9";
    program_cfg(8'h70, 18'h00100, 7, 20, 1, 1'b1, 1'b0);
    tick(5);
    program_cfg(8'h70, 18'h00100, 7, 20, 1, 1'b0, 1'b0);
    tick(2);
    program_cfg(8'h70, 18'h00100, 7, 20, 1, 1'b1, 1'b0);
    tick(20);

    // R10: reset while sweeping returns to pass-through
    cur_tag = "R10";
    rst_n = 1'b0;
    program_cfg(8'h70, 18'h00100, 7, 20, 1, 1'b0, 1'b0);
    tick(3);
    rst_n = 1'b1;
    tick(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog R10 run actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule